// File: doc/BRIEF.md
# NAND Flash Parity Accumulator with Pin Control

This block sits between a byte-wide register bus and the data and control pins of a raw NAND flash device. Every byte that software moves through the flash data port, in either direction, passes straight to or from the device pins. In the same cycle it is folded into a running single-error-correcting Hamming code. A 256-byte chunk yields 16 bits of line parity and 6 bits of column parity. Software turns these into three code bytes: the line-parity bytes and the column parity shifted left by two are each inverted, with the two low bits of the last byte set. The code corrects one flipped bit per chunk.

A byte counter tracks how many data bytes have been folded in since the last clear. It wraps at 256, so a complete chunk leaves it at zero, and software reads any other value as a fault. Writing to the clear register starts a new chunk. The same register bank holds the flash control register. That register drives the two active-low chip enables, the command-latch and address-latch strobes and the active-low write-protect pin, and it returns the ready/busy input. Bytes moved while either latch strobe is set are command or address bytes, and they are left out of the code.

Top module: `flash_ecc_port`

## Requirements
- R1: After a synchronous reset, line parity, column parity and the byte counter read 0. Both chip-enable pins are high (deasserted), the write-protect pin is low (protected), and both latch strobes are low. The control register therefore reads bits 4..0 as 5'b10001.
- R2: A write to the control register at offset 0x18 sets the pins from the next cycle on: bit 0 drives chip enable 0 (active low), bit 1 the command latch, bit 2 the address latch, bit 3 write protect (0 means protected) and bit 4 chip enable 1 (active low). A read returns these five bits in the same positions.
- R3: Control register bit 5 reads the live ready/busy input, with 1 meaning ready. Bits 7..6 read 0, and writes to bits 7..5 have no effect.
- R4: A write to the data port at offset 0x14 presents the write data on the flash output bus with the write strobe high in that same cycle. A read of the data port returns the flash input bus with the read strobe high in that same cycle.
- R5: For a byte at chunk position a (the counter value before the byte), let p be the XOR of its 8 bits. For each address bit i from 0 to 7, p is XORed into line parity bit 2i when a[i] is 0 and into bit 2i+1 when a[i] is 1. Bits 7..0 are read at offset 0x00 and bits 15..8 at offset 0x04.
- R6: For each bit-index bit j from 0 to 2, column parity bit 2j accumulates the XOR of the data bits whose index has bit j equal to 0, and bit 2j+1 those whose index has bit j equal to 1. It is read in bits 5..0 at offset 0x08, with bits 7..6 reading 0.
- R7: The byte counter at offset 0x0C advances by one for every data-port byte that is folded in, and it wraps modulo 256, so a full 256-byte chunk leaves it at 0.
- R8: While the command-latch or address-latch control bit is 1, data-port transfers still reach the pins but leave the parities and the counter unchanged.
- R9: Any write to offset 0x10 zeroes both parities and the counter in the next cycle and leaves the control register unchanged.
- R10: Writes to offsets 0x00 through 0x0C are ignored, reads of unmapped offsets return 0, and the results change only on a data-port transfer or a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| fl_dout | output | 8 | Byte driven to the flash data pins |
| fl_din | input | 8 | Byte returned by the flash data pins |
| fl_wr_stb | output | 1 | Flash data write strobe |
| fl_rd_stb | output | 1 | Flash data read strobe |
| fl_ce0_n | output | 1 | Chip enable 0, active low |
| fl_ce1_n | output | 1 | Chip enable 1, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_wp_n | output | 1 | Write protect, active low |
| fl_rdy | input | 1 | Ready/busy from the device, 1 = ready |

## Verification
The bench feeds complete 256-byte chunks and checks that the counter returns to zero. A counter of the wrong width, or one that saturates, would leave a non-zero value behind. Single bytes at known positions (0x01 at position 0, 0x80 at position 3) pin down which parity bit belongs to the even half and which to the odd half, so any swapped half or index shows up as a wrong constant. Transfers made with the command or address latch set must leave the results untouched, and a clear in the middle of a stream must not disturb the control pins. A design that let latch cycles through would corrupt the code, and one that tied clear to the control register would drop chip enable.

// File: rtl/flash_ecc_pkg.sv
package flash_ecc_pkg;

    localparam int BYTE_W = 8;

    // register offsets (byte addresses)
    localparam logic [7:0] OFS_LPLO = 8'h00;
    localparam logic [7:0] OFS_LPHI = 8'h04;
    localparam logic [7:0] OFS_CPAR = 8'h08;
    localparam logic [7:0] OFS_BCNT = 8'h0C;
    localparam logic [7:0] OFS_CLR  = 8'h10;
    localparam logic [7:0] OFS_DATA = 8'h14;
    localparam logic [7:0] OFS_CTL  = 8'h18;

    // control register layout, bit 4 down to bit 0
    typedef struct packed {
        logic ce1_n;
        logic wp_n;
        logic ale;
        logic cle;
        logic ce0_n;
    } fctl_t;

    localparam fctl_t CTL_RST = '{ce1_n: 1'b1, wp_n: 1'b0, ale: 1'b0, cle: 1'b0, ce0_n: 1'b1};

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LPLO,
        SEL_LPHI,
        SEL_CPAR,
        SEL_BCNT,
        SEL_CLR,
        SEL_DATA,
        SEL_CTL
    } reg_sel_e;

    // strobes derived from one bus access
    typedef struct packed {
        logic ctl_we;
        logic clr;
        logic dat_wr;
        logic dat_rd;
    } bus_evt_t;

    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_LPLO: s = SEL_LPLO;
            OFS_LPHI: s = SEL_LPHI;
            OFS_CPAR: s = SEL_CPAR;
            OFS_BCNT: s = SEL_BCNT;
            OFS_CLR:  s = SEL_CLR;
            OFS_DATA: s = SEL_DATA;
            OFS_CTL:  s = SEL_CTL;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fecc_accum.sv
module fecc_accum #(
    parameter int AW = 8,
    parameter int DW = 8,
    localparam int IW  = $clog2(DW),
    localparam int CPW = 2 * IW,
    localparam int LPW = 2 * AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           take,
    input  logic [DW-1:0]  din,
    output logic [LPW-1:0] lpar,
    output logic [CPW-1:0] cpar,
    output logic [AW-1:0]  bcnt
);

    logic           row_par;
    logic [LPW-1:0] lp_upd;
    logic [CPW-1:0] cp_upd;

    assign row_par = ^din;

    // line parity: one even/odd pair per position bit
    for (genvar i = 0; i < AW; i++) begin : g_line
        assign lp_upd[2*i]   = row_par & ~bcnt[i];
        assign lp_upd[2*i+1] = row_par &  bcnt[i];
    end

    // column parity: one even/odd pair per bit-index bit
    for (genvar j = 0; j < IW; j++) begin : g_col
        logic [DW-1:0] grp_lo;
        logic [DW-1:0] grp_hi;
        for (genvar b = 0; b < DW; b++) begin : g_bit
            if (((b >> j) & 1) == 0) begin : g_lo
                assign grp_lo[b] = din[b];
                assign grp_hi[b] = 1'b0;
            end else begin : g_hi
                assign grp_lo[b] = 1'b0;
                assign grp_hi[b] = din[b];
            end
        end
        assign cp_upd[2*j]   = ^grp_lo;
        assign cp_upd[2*j+1] = ^grp_hi;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lpar <= '0;
            cpar <= '0;
            bcnt <= '0;
        end else if (take) begin
            lpar <= lpar ^ lp_upd;
            cpar <= cpar ^ cp_upd;
            bcnt <= bcnt + 1'b1;
        end
    end

endmodule

// File: rtl/fecc_ctl_reg.sv
module fecc_ctl_reg
    import flash_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [4:0] wdata,
    output fctl_t      ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= CTL_RST;
        end else if (wr_en) begin
            ctl <= fctl_t'(wdata);
        end
    end

endmodule

// File: rtl/fecc_regmux.sv
module fecc_regmux
    import flash_ecc_pkg::*;
(
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [7:0]  addr_b,
    input  logic [7:0]  rd_lp_lo,
    input  logic [7:0]  rd_lp_hi,
    input  logic [7:0]  rd_cp,
    input  logic [7:0]  rd_cnt,
    input  fctl_t       ctl,
    input  logic        rdy,
    input  logic [7:0]  fl_din,
    output logic [7:0]  rdata,
    output bus_evt_t    evt
);

    reg_sel_e sel;

    assign sel = decode_ofs(addr_b);

    always_comb begin
        evt        = '0;
        evt.ctl_we = bus_sel &  bus_we & (sel == SEL_CTL);
        evt.clr    = bus_sel &  bus_we & (sel == SEL_CLR);
        evt.dat_wr = bus_sel &  bus_we & (sel == SEL_DATA);
        evt.dat_rd = bus_sel & ~bus_we & (sel == SEL_DATA);
    end

    always_comb begin
        unique case (sel)
            SEL_LPLO: rdata = rd_lp_lo;
            SEL_LPHI: rdata = rd_lp_hi;
            SEL_CPAR: rdata = rd_cp;
            SEL_BCNT: rdata = rd_cnt;
            SEL_DATA: rdata = fl_din;
            SEL_CTL:  rdata = {2'b00, rdy, 5'(ctl)};
            default:  rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/flash_ecc_port.sv
module flash_ecc_port
    import flash_ecc_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int CHUNK_AW = 8,
    localparam int LPW = 2 * CHUNK_AW,
    localparam int CPW = 2 * $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        fl_dout,
    input  logic [7:0]        fl_din,
    output logic              fl_wr_stb,
    output logic              fl_rd_stb,
    output logic              fl_ce0_n,
    output logic              fl_ce1_n,
    output logic              fl_cle,
    output logic              fl_ale,
    output logic              fl_wp_n,
    input  logic              fl_rdy
);

    logic [7:0]          addr_b;
    fctl_t               ctl;
    bus_evt_t            evt;
    logic                take;
    logic [BYTE_W-1:0]   feed;
    logic [LPW-1:0]      lpar;
    logic [CPW-1:0]      cpar;
    logic [CHUNK_AW-1:0] bcnt;
    logic [15:0]         lp_w;
    logic [7:0]          rd_lp_lo;
    logic [7:0]          rd_lp_hi;
    logic [7:0]          rd_cp;
    logic [7:0]          rd_cnt;

    assign addr_b = 8'(bus_addr);

    fecc_regmux u_mux (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .addr_b   (addr_b),
        .rd_lp_lo (rd_lp_lo),
        .rd_lp_hi (rd_lp_hi),
        .rd_cp    (rd_cp),
        .rd_cnt   (rd_cnt),
        .ctl      (ctl),
        .rdy      (fl_rdy),
        .fl_din   (fl_din),
        .rdata    (bus_rdata),
        .evt      (evt)
    );

    fecc_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (evt.ctl_we),
        .wdata (bus_wdata[4:0]),
        .ctl   (ctl)
    );

    // command and address bytes are kept out of the code
    assign take = (evt.dat_wr | evt.dat_rd) & ~ctl.cle & ~ctl.ale;
    assign feed = evt.dat_wr ? bus_wdata : fl_din;

    fecc_accum #(
        .AW (CHUNK_AW),
        .DW (BYTE_W)
    ) u_acc (
        .clk  (clk),
        .rst  (rst),
        .clr  (evt.clr),
        .take (take),
        .din  (feed),
        .lpar (lpar),
        .cpar (cpar),
        .bcnt (bcnt)
    );

    assign lp_w     = 16'(lpar);
    assign rd_lp_lo = lp_w[7:0];
    assign rd_lp_hi = lp_w[15:8];
    assign rd_cp    = 8'(cpar);
    assign rd_cnt   = 8'(bcnt);

    assign fl_dout   = bus_wdata;
    assign fl_wr_stb = evt.dat_wr;
    assign fl_rd_stb = evt.dat_rd;
    assign fl_ce0_n  = ctl.ce0_n;
    assign fl_ce1_n  = ctl.ce1_n;
    assign fl_cle    = ctl.cle;
    assign fl_ale    = ctl.ale;
    assign fl_wp_n   = ctl.wp_n;

endmodule

// File: rtl/flash_ecc_port_chk.sv
module flash_ecc_port_chk
    import flash_ecc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [7:0] addr_b,
    input logic [7:0] bus_wdata,
    input logic [7:0] rd_lp_lo,
    input logic [7:0] rd_lp_hi,
    input logic [7:0] rd_cp,
    input logic [7:0] rd_cnt,
    input logic       fl_ce0_n,
    input logic       fl_ce1_n,
    input logic       fl_cle,
    input logic       fl_ale,
    input logic       fl_wp_n
);

    logic dat_acc;
    logic clr_acc;
    logic ctl_acc;

    assign dat_acc = bus_sel && (addr_b == OFS_DATA);
    assign clr_acc = bus_sel && bus_we && (addr_b == OFS_CLR);
    assign ctl_acc = bus_sel && bus_we && (addr_b == OFS_CTL);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rd_cnt == 8'h00 && rd_lp_lo == 8'h00 && rd_lp_hi == 8'h00 && rd_cp == 8'h00
                 && fl_ce0_n && fl_ce1_n && !fl_wp_n && !fl_cle && !fl_ale));

    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_acc |=> ({fl_ce1_n, fl_wp_n, fl_ale, fl_cle, fl_ce0_n} == $past(bus_wdata[4:0])));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_acc && !fl_cle && !fl_ale) |=> (rd_cnt == 8'($past(rd_cnt) + 8'd1)));

    // R8
    latch_pause_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_acc && (fl_cle || fl_ale)) |=>
            ($stable(rd_cnt) && $stable(rd_lp_lo) && $stable(rd_lp_hi) && $stable(rd_cp)));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_acc |=> (rd_cnt == 8'h00 && rd_lp_lo == 8'h00 && rd_lp_hi == 8'h00 && rd_cp == 8'h00));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(dat_acc || clr_acc) |=>
            ($stable(rd_cnt) && $stable(rd_lp_lo) && $stable(rd_lp_hi) && $stable(rd_cp)));

endmodule

bind flash_ecc_port flash_ecc_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .addr_b    (addr_b),
    .bus_wdata (bus_wdata),
    .rd_lp_lo  (rd_lp_lo),
    .rd_lp_hi  (rd_lp_hi),
    .rd_cp     (rd_cp),
    .rd_cnt    (rd_cnt),
    .fl_ce0_n  (fl_ce0_n),
    .fl_ce1_n  (fl_ce1_n),
    .fl_cle    (fl_cle),
    .fl_ale    (fl_ale),
    .fl_wp_n   (fl_wp_n)
);

// File: tb/flash_ecc_port_tb.sv
module flash_ecc_port_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] fl_dout;
    logic [7:0] fl_din = '0;
    logic       fl_wr_stb;
    logic       fl_rd_stb;
    logic       fl_ce0_n;
    logic       fl_ce1_n;
    logic       fl_cle;
    logic       fl_ale;
    logic       fl_wp_n;
    logic       fl_rdy = 1'b1;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_lp;
    logic [5:0]  m_cp;
    logic [7:0]  m_cnt;
    logic [4:0]  m_ctl;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_ecc_port u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .fl_dout   (fl_dout),
        .fl_din    (fl_din),
        .fl_wr_stb (fl_wr_stb),
        .fl_rd_stb (fl_rd_stb),
        .fl_ce0_n  (fl_ce0_n),
        .fl_ce1_n  (fl_ce1_n),
        .fl_cle    (fl_cle),
        .fl_ale    (fl_ale),
        .fl_wp_n   (fl_wp_n),
        .fl_rdy    (fl_rdy)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // behavioural model of folding one byte in
    task automatic model_fold(input logic [7:0] d);
        int ones = 0;
        if (m_ctl[1] || m_ctl[2]) return;
        for (int b = 0; b < 8; b++) begin
            if (d[b]) begin
                ones++;
                for (int j = 0; j < 3; j++) m_cp[2*j + ((b >> j) & 1)] ^= 1'b1;
            end
        end
        if (ones % 2 == 1)
            for (int i = 0; i < 8; i++) m_lp[2*i + ((m_cnt >> i) & 1)] ^= 1'b1;
        m_cnt = m_cnt + 8'd1;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a[4:0]; bus_wdata = d;
        #1;
        if (a == 8'h14) begin
            check("R4 dout", fl_dout, d);
            check("R4 wr_stb", {7'b0, fl_wr_stb}, 8'h01);
        end
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
        if (a == 8'h18) m_ctl = d[4:0];
        if (a == 8'h10) begin m_lp = '0; m_cp = '0; m_cnt = '0; end
        if (a == 8'h14) model_fold(d);
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a[4:0];
        #1;
        d = bus_rdata;
        if (a == 8'h14) check("R4 rd_stb", {7'b0, fl_rd_stb}, 8'h01);
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        if (a == 8'h14) model_fold(fl_din);
    endtask

    task automatic cmp_results(input string tag);
        logic [7:0] v;
        bus_rd(8'h00, v); check({"R5 lp_lo ", tag}, v, m_lp[7:0]);
        bus_rd(8'h04, v); check({"R5 lp_hi ", tag}, v, m_lp[15:8]);
        bus_rd(8'h08, v); check({"R6 cp ", tag}, v, {2'b00, m_cp});
        bus_rd(8'h0C, v); check({"R7 cnt ", tag}, v, m_cnt);
    endtask

    // pins compared against the model on every clock
    always @(posedge clk) begin
        #3;
        if (!rst && !done) begin
            check("R2 ce0_n", {7'b0, fl_ce0_n}, {7'b0, m_ctl[0]});
            check("R2 cle",   {7'b0, fl_cle},   {7'b0, m_ctl[1]});
            check("R2 ale",   {7'b0, fl_ale},   {7'b0, m_ctl[2]});
            check("R2 wp_n",  {7'b0, fl_wp_n},  {7'b0, m_ctl[3]});
            check("R2 ce1_n", {7'b0, fl_ce1_n}, {7'b0, m_ctl[4]});
            check("R4 wr_stb idle", {7'b0, fl_wr_stb},
                  {7'b0, bus_sel && bus_we && bus_addr == 5'h14});
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] d;
        m_lp = '0; m_cp = '0; m_cnt = '0; m_ctl = 5'b10001;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        cmp_results("R1 reset");
        bus_rd(8'h18, v); check("R1 ctl reset", v, 8'h31);

        // R2 / R3 control register
        bus_wr(8'h18, 8'h0A); bus_rd(8'h18, v); check("R2 ctl rb", v, 8'h2A);
        fl_rdy = 1'b0;
        bus_rd(8'h18, v); check("R3 busy", v, 8'h0A);
        fl_rdy = 1'b1;
        bus_wr(8'h18, 8'hFF); bus_rd(8'h18, v); check("R3 upper ignored", v, 8'h3F);
        bus_wr(8'h18, 8'h08); bus_rd(8'h18, v); check("R2 enabled", v, 8'h28);

        // R5 / R6 directed single-byte signatures
        bus_wr(8'h10, 8'h00);
        bus_wr(8'h14, 8'h01);
        bus_rd(8'h00, v); check("R5 first byte lo", v, 8'h55);
        bus_rd(8'h04, v); check("R5 first byte hi", v, 8'h55);
        bus_rd(8'h08, v); check("R6 bit0 column", v, 8'h15);
        bus_wr(8'h14, 8'h00);
        bus_wr(8'h14, 8'h00);
        bus_wr(8'h14, 8'h80);
        bus_rd(8'h00, v); check("R5 pos3 lo", v, 8'h0F);
        bus_rd(8'h04, v); check("R5 pos3 hi", v, 8'h00);
        bus_rd(8'h08, v); check("R6 bit7 column", v, 8'h3F);
        bus_rd(8'h0C, v); check("R7 count4", v, 8'h04);

        // R7 full chunk of random writes
        bus_wr(8'h10, 8'h00);
        for (int k = 0; k < 256; k++) bus_wr(8'h14, 8'($urandom));
        cmp_results("write chunk");
        bus_rd(8'h0C, v); check("R7 wrap zero", v, 8'h00);

        // R7 full chunk of 0x01 -> all parities cancel
        bus_wr(8'h10, 8'h00);
        for (int k = 0; k < 256; k++) bus_wr(8'h14, 8'h01);
        bus_rd(8'h00, v); check("R5 uniform lo", v, 8'h00);
        bus_rd(8'h08, v); check("R6 uniform cp", v, 8'h00);

        // R4 partial chunk through data reads
        bus_wr(8'h10, 8'h00);
        for (int k = 0; k < 100; k++) begin
            fl_din = 8'($urandom);
            bus_rd(8'h14, d);
            check("R4 read data", d, fl_din);
        end
        cmp_results("read partial");

        // R8 command and address latch bytes excluded
        bus_wr(8'h18, 8'h0A);
        bus_wr(8'h14, 8'h5A);
        fl_din = 8'h3C; bus_rd(8'h14, d);
        bus_wr(8'h18, 8'h0C);
        bus_wr(8'h14, 8'hE7);
        bus_wr(8'h18, 8'h08);
        cmp_results("R8 latched");
        bus_rd(8'h0C, v); check("R8 count held", v, 8'd100);

        // R10 writes to result registers ignored, unmapped read
        bus_wr(8'h00, 8'hFF); bus_wr(8'h04, 8'hFF);
        bus_wr(8'h08, 8'hFF); bus_wr(8'h0C, 8'hFF);
        cmp_results("R10 ro");
        bus_rd(8'h1C, v); check("R10 unmapped", v, 8'h00);

        // R9 clear mid-stream keeps control
        bus_wr(8'h14, 8'hA5);
        bus_wr(8'h10, 8'h77);
        cmp_results("R9 clear");
        bus_rd(8'h18, v); check("R9 ctl kept", v, 8'h28);
        bus_wr(8'h14, 8'h01);
        bus_rd(8'h00, v); check("R9 restart lo", v, 8'h55);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule